// File: doc/BRIEF.md
# Monochrome Graphics Adapter Control Registers

This block holds the programmable controls of a monochrome text/graphics display adapter that offers one 720x348 bitmap mode next to its text mode. It sits on an 8-bit I/O port bus and decodes the full 16-bit port address. Software writes a mode register that selects text or graphics, enables or blanks the video, turns on character blinking and picks one of two display pages. A separate configuration register decides which of those choices may take effect. Graphics can be forbidden outright, and the second page can be kept out of reach.

A light-pen latch is set by a write to one strobe port and cleared by a write to another. The data of both writes is ignored. A rising edge on a trigger pin, which stands in for the pen hardware, also sets the latch. A read-only status port combines the latch with live sync, blanking and video inputs from the display timing logic. The decoded controls (graphics enable, display enable, blink enable and the page base segment) drive the rest of the display pipeline.

Port map: mode 03B8h (read/write), set-pen strobe 03B9h, status 03BAh (read), clear-pen strobe 03BBh, configuration 03BFh (write).

Top module: `mono_gfx_regs`

## Requirements
- R1: After reset, gfx_en, disp_en and blink_en are 0, page_seg is B000h, the pen latch (status bit 1) is 0, and the mode register reads back 00h.
- R2: Writes take effect only when all 16 address bits match a register address. A write to an alias that shares the low 10 bits, such as 07B8h, changes nothing.
- R3: The cycle after a write to 03B8h, disp_en equals data bit 3 and blink_en equals data bit 5.
- R4: gfx_en is 1 only while mode bit 1 and configuration bit 0 are both 1. Clearing configuration bit 0 forces text mode, and the stored mode bit 1 is kept.
- R5: A mode write stores bit 7 as (data bit 7 AND configuration bit 1). page_seg is B800h while the stored bit 7 and configuration bit 1 are both 1, and B000h otherwise.
- R6: Any write to 03B9h sets the pen latch, whatever the data.
- R7: Any write to 03BBh clears the pen latch, whatever the data, unless a set happens in the same cycle.
- R8: A 0-to-1 transition of pen_trig, as sampled on the clock, sets the latch. A trigger held high does not set the latch again after a clear.
- R9: When a clear write and a set (a strobe or a trigger edge) happen in the same cycle, the latch ends up set.
- R10: A read of 03BAh returns bit 0 = hblank_act, bit 1 = pen latch, bit 3 = video_din, bit 7 = NOT vsync_act, and all other bits 0, combinationally.
- R11: A read of 03B8h returns the stored mode byte. A read of any other address, or any cycle without io_rd, returns 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe |
| io_rdata | output | 8 | Read data, combinational |
| hblank_act | input | 1 | Horizontal sync, border or blanking active |
| vsync_act | input | 1 | Vertical sync active |
| video_din | input | 1 | Current video data bit |
| pen_trig | input | 1 | Light-pen trigger, synchronous to clk |
| gfx_en | output | 1 | Graphics mode in effect |
| disp_en | output | 1 | Video enabled (0 = blanked) |
| blink_en | output | 1 | Text blinking enabled |
| page_seg | output | 16 | Segment of the active display page |

## Verification
The hardest case to reach is a clear-strobe write that lands in the same clock as a fresh trigger edge, or as a set strobe. A second hard case is a trigger held high across a clear. In both, the outcome depends on the edge history and not on the current pin level. Directed sequences raise pen_trig on the exact cycle of a 03BBh write, and then hold it high through a further clear. A random phase mixes strobes, trigger toggles, masked mode and configuration writes, and random addresses. It compares each result with a model that tracks the previous trigger sample.

// File: rtl/mono_gfx_pkg.sv
`timescale 1ns/1ps
// Shared port addresses, bit positions and decode record for the
// monochrome graphics adapter control registers.
package mono_gfx_pkg;
    localparam logic [15:0] PORT_MODE = 16'h03B8;
    localparam logic [15:0] PORT_PSET = 16'h03B9;
    localparam logic [15:0] PORT_STAT = 16'h03BA;
    localparam logic [15:0] PORT_PCLR = 16'h03BB;
    localparam logic [15:0] PORT_CFG  = 16'h03BF;

    localparam int MODE_GFX   = 1;
    localparam int MODE_DISP  = 3;
    localparam int MODE_BLINK = 5;
    localparam int MODE_PAGE  = 7;
    localparam int CFG_GFX_OK  = 0;
    localparam int CFG_PAGE_OK = 1;

    localparam logic [15:0] SEG_PAGE0 = 16'hB000;
    localparam logic [15:0] SEG_PAGE1 = 16'hB800;

    typedef struct packed {
        logic mode_wr;
        logic cfg_wr;
        logic pset_wr;
        logic pclr_wr;
        logic stat_rd;
        logic mode_rd;
    } io_sel_t;
endpackage

// File: rtl/mono_gfx_decode.sv
`timescale 1ns/1ps
// Full-width port address decoder. Assumes the address is stable while a
// strobe is high. Produces one select per register access kind.
module mono_gfx_decode
    import mono_gfx_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output io_sel_t           sel
);
    localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(PORT_MODE);
    localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(PORT_CFG);
    localparam logic [ADDR_W-1:0] A_PSET = ADDR_W'(PORT_PSET);
    localparam logic [ADDR_W-1:0] A_PCLR = ADDR_W'(PORT_PCLR);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(PORT_STAT);

    // Compare every address bit against each register port.
    always_comb begin
        sel.mode_wr = wr && (addr == A_MODE);
        sel.cfg_wr  = wr && (addr == A_CFG);
        sel.pset_wr = wr && (addr == A_PSET);
        sel.pclr_wr = wr && (addr == A_PCLR);
        sel.stat_rd = rd && (addr == A_STAT);
        sel.mode_rd = rd && (addr == A_MODE);
    end
endmodule

// File: rtl/mono_gfx_mode.sv
`timescale 1ns/1ps
// Mode and configuration registers plus the decoded display controls.
// The configuration register gates graphics at the output and gates the
// page bit both at store time and at the output.
module mono_gfx_mode
    import mono_gfx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SEG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic              cfg_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] mode_q,
    output logic [DATA_W-1:0] cfg_q,
    output logic              gfx_en,
    output logic              disp_en,
    output logic              blink_en,
    output logic [SEG_W-1:0]  page_seg
);
    logic [DATA_W-1:0] mode_next;

    // Mask the page bit of an incoming mode byte with the page permission.
    always_comb begin
        mode_next            = wdata;
        mode_next[MODE_PAGE] = wdata[MODE_PAGE] & cfg_q[CFG_PAGE_OK];
    end

    // Hold the mode byte.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= '0;
        else if (mode_wr) mode_q <= mode_next;
    end

    // Hold the configuration byte.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_wr) cfg_q <= wdata;
    end

    // Derive the controls that leave the block.
    always_comb begin
        gfx_en   = mode_q[MODE_GFX] & cfg_q[CFG_GFX_OK];
        disp_en  = mode_q[MODE_DISP];
        blink_en = mode_q[MODE_BLINK];
        page_seg = (mode_q[MODE_PAGE] & cfg_q[CFG_PAGE_OK]) ? SEG_W'(SEG_PAGE1)
                                                            : SEG_W'(SEG_PAGE0);
    end
endmodule

// File: rtl/mono_gfx_pen.sv
`timescale 1ns/1ps
// Light-pen latch. Assumes pen_trig is already synchronous to clk.
// The set sources (strobe, trigger edge) win over the clear strobe.
module mono_gfx_pen (
    input  logic clk,
    input  logic rst_n,
    input  logic set_wr,
    input  logic clr_wr,
    input  logic trig,
    output logic latch
);
    logic trig_prev;
    logic trig_edge;

    // Detect a low-to-high step of the trigger pin.
    always_comb trig_edge = trig & ~trig_prev;

    // Remember the previous trigger sample.
    always_ff @(posedge clk) begin
        if (!rst_n) trig_prev <= 1'b0;
        else        trig_prev <= trig;
    end

    // Update the latch with set taking priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                  latch <= 1'b0;
        else if (set_wr | trig_edge) latch <= 1'b1;
        else if (clr_wr)             latch <= 1'b0;
    end
endmodule

// File: rtl/mono_gfx_regs.sv
`timescale 1ns/1ps
// Top: monochrome graphics adapter control registers on an 8-bit I/O bus.
// Read data is combinational. Status merges live timing inputs with the
// pen latch.
module mono_gfx_regs
    import mono_gfx_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int SEG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    input  logic              io_wr,
    input  logic              io_rd,
    output logic [DATA_W-1:0] io_rdata,
    input  logic              hblank_act,
    input  logic              vsync_act,
    input  logic              video_din,
    input  logic              pen_trig,
    output logic              gfx_en,
    output logic              disp_en,
    output logic              blink_en,
    output logic [SEG_W-1:0]  page_seg
);
    io_sel_t           sel;
    logic [DATA_W-1:0] mode_q;
    logic [DATA_W-1:0] cfg_q;
    logic              pen_latch;
    logic [DATA_W-1:0] status;

    mono_gfx_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (io_addr),
        .wr   (io_wr),
        .rd   (io_rd),
        .sel  (sel)
    );

    mono_gfx_mode #(.DATA_W(DATA_W), .SEG_W(SEG_W)) u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_wr  (sel.mode_wr),
        .cfg_wr   (sel.cfg_wr),
        .wdata    (io_wdata),
        .mode_q   (mode_q),
        .cfg_q    (cfg_q),
        .gfx_en   (gfx_en),
        .disp_en  (disp_en),
        .blink_en (blink_en),
        .page_seg (page_seg)
    );

    mono_gfx_pen u_pen (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_wr (sel.pset_wr),
        .clr_wr (sel.pclr_wr),
        .trig   (pen_trig),
        .latch  (pen_latch)
    );

    // Assemble the status byte from live inputs and the latch.
    always_comb begin
        status    = '0;
        status[0] = hblank_act;
        status[1] = pen_latch;
        status[3] = video_din;
        status[7] = ~vsync_act;
    end

    // Select read data. Unmapped ports and idle cycles give zero.
    always_comb begin
        if (sel.stat_rd)      io_rdata = status;
        else if (sel.mode_rd) io_rdata = mode_q;
        else                  io_rdata = '0;
    end
endmodule

// File: rtl/mono_gfx_regs_chk.sv
`timescale 1ns/1ps
// Property checker for mono_gfx_regs, bound to every instance.
module mono_gfx_regs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] io_addr,
    input logic [7:0]  io_wdata,
    input logic        io_wr,
    input logic        io_rd,
    input logic [7:0]  io_rdata,
    input logic        hblank_act,
    input logic        vsync_act,
    input logic        pen_trig,
    input logic        pen_latch,
    input logic        gfx_en,
    input logic        disp_en,
    input logic [15:0] page_seg
);
    // R3
    disp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == 16'h03B8) |=> (disp_en == $past(io_wdata[3])));
    // R4
    gfx_forced_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == 16'h03BF && !io_wdata[0]) |=> !gfx_en);
    // R5
    page_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == 16'h03BF && !io_wdata[1]) |=> (page_seg == 16'hB000));
    // R6
    pen_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == 16'h03B9) |=> pen_latch);
    // R7
    pen_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == 16'h03BB && !pen_trig) |=> !pen_latch);
    // R8
    trig_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pen_trig && !$past(pen_trig)) |=> pen_latch);
    // R10
    status_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_addr == 16'h03BA) |->
            (io_rdata[1] == pen_latch && io_rdata[0] == hblank_act &&
             io_rdata[7] == !vsync_act));
endmodule

bind mono_gfx_regs mono_gfx_regs_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .io_addr    (io_addr),
    .io_wdata   (io_wdata),
    .io_wr      (io_wr),
    .io_rd      (io_rd),
    .io_rdata   (io_rdata),
    .hblank_act (hblank_act),
    .vsync_act  (vsync_act),
    .pen_trig   (pen_trig),
    .pen_latch  (pen_latch),
    .gfx_en     (gfx_en),
    .disp_en    (disp_en),
    .page_seg   (page_seg)
);

// File: tb/mono_gfx_regs_test.sv
`timescale 1ns/1ps
module mono_gfx_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_rdata;
    logic        hblank_act = 1'b0;
    logic        vsync_act = 1'b0;
    logic        video_din = 1'b0;
    logic        pen_trig = 1'b0;
    logic        gfx_en, disp_en, blink_en;
    logic [15:0] page_seg;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    // model state
    logic [7:0] m_mode = '0;
    logic [7:0] m_cfg = '0;
    logic       m_latch = 1'b0;
    logic       m_prev = 1'b0;

    always #10 clk = ~clk;

    mono_gfx_regs uut (.*);

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_status(input logic l);
        return {~vsync_act, 3'b000, video_din, 1'b0, l, hblank_act};
    endfunction

    function automatic logic [15:0] exp_seg();
        return (m_mode[7] && m_cfg[1]) ? 16'hB800 : 16'hB000;
    endfunction

    // One bus cycle with optional write, then update the model.
    task automatic step(input logic wr, input logic [15:0] a, input logic [7:0] d, input logic trig);
        logic edge_s;
        @(negedge clk);
        io_wr = wr; io_addr = a; io_wdata = d; pen_trig = trig;
        @(posedge clk);
        #1;
        io_wr = 1'b0;
        edge_s = trig & ~m_prev;
        m_prev = trig;
        if (wr && a == 16'h03B8) m_mode = {d[7] & m_cfg[1], d[6:0]};
        if (wr && a == 16'h03BF) m_cfg = d;
        if ((wr && a == 16'h03B9) || edge_s) m_latch = 1'b1;
        else if (wr && a == 16'h03BB) m_latch = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] v);
        io_rd = 1'b1; io_addr = a;
        #1;
        v = io_rdata;
        io_rd = 1'b0;
        #1;
    endtask

    task automatic check_all(input string tag);
        logic [7:0] v;
        chk({tag, " R4 gfx"}, {15'd0, gfx_en}, {15'd0, m_mode[1] & m_cfg[0]});
        chk({tag, " R3 disp"}, {15'd0, disp_en}, {15'd0, m_mode[3]});
        chk({tag, " R3 blink"}, {15'd0, blink_en}, {15'd0, m_mode[5]});
        chk({tag, " R5 page"}, page_seg, exp_seg());
        rd(16'h03BA, v);
        chk({tag, " R10 status"}, {8'd0, v}, {8'd0, exp_status(m_latch)});
        rd(16'h03B8, v);
        chk({tag, " R11 mode rd"}, {8'd0, v}, {8'd0, m_mode});
    endtask

    initial begin
        #(20ns * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R1 reset state
        check_all("R1");
        rd(16'h03BF, v);
        chk("R11 cfg not readable", {8'd0, v}, 16'h0000);
        v = io_rdata;
        chk("R11 idle rdata", {8'd0, v}, 16'h0000);

        // R2 alias writes ignored
        step(1, 16'h07B8, 8'hFF, 0); check_all("R2 alias mode");
        step(1, 16'h83B9, 8'hFF, 0); check_all("R2 alias pset");

        // R5 page masked while paging disallowed
        step(1, 16'h03B8, 8'hAA, 0); check_all("R5 masked");
        step(1, 16'h03BF, 8'h03, 0);
        step(1, 16'h03B8, 8'h8A, 0); check_all("R5 page1");
        chk("R5 page1 seg", page_seg, 16'hB800);
        // R4 forbid graphics after selection, stored bit kept
        step(1, 16'h03BF, 8'h00, 0); check_all("R4 forced text");
        chk("R4 gfx off", {15'd0, gfx_en}, 16'h0000);

        // R6 / R7 strobes with arbitrary data
        step(1, 16'h03B9, 8'h00, 0); check_all("R6 set");
        step(1, 16'h03BB, 8'h5C, 0); check_all("R7 clear");
        // R9 clear together with trigger edge
        step(1, 16'h03BB, 8'hFF, 1); check_all("R9 clr+edge");
        chk("R9 latch", {15'd0, m_latch}, 16'h0001);
        // R8 held trigger does not re-set after clear
        step(1, 16'h03BB, 8'h00, 1); check_all("R8 held clear");
        step(0, 16'h0000, 8'h00, 1); check_all("R8 held idle");
        step(0, 16'h0000, 8'h00, 0);
        step(0, 16'h0000, 8'h00, 1); check_all("R8 new edge");

        // Random mix
        for (int i = 0; i < 300; i++) begin
            logic [15:0] a;
            int k;
            k = $urandom_range(0, 6);
            case (k)
                0: a = 16'h03B8;
                1: a = 16'h03BF;
                2: a = 16'h03B9;
                3: a = 16'h03BB;
                4: a = 16'h03BA;
                default: a = 16'($urandom);
            endcase
            hblank_act = 1'($urandom);
            vsync_act  = 1'($urandom);
            video_din  = 1'($urandom);
            step(1'($urandom_range(0, 3) != 0), a, 8'($urandom), 1'($urandom));
            check_all("rand");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule